// File: doc/BRIEF.md
# Cross-Lane Operand Permutation Unit

This block rearranges one vector operand across a 64-lane wavefront on its way to the ALU. The wavefront is treated as a hierarchy: four rows of sixteen lanes, each row split into four banks of four consecutive lanes. A 9-bit control code picks one of several data movements. These are a free permute inside every four-lane group, shifts and rotates inside each row, one-lane shifts and rotates across the whole wave, mirrors over a row or half row, and broadcasts from one row into the rows above it.

Each output lane either takes the value of a source lane or falls back to a default. A lane falls back when its source lies outside the legal range, or when a broadcast does not reach it. With the bound flag clear the fallback is the lane's own input value; with it set the fallback is zero. The row and bank masks switch lanes off entirely, and a disabled lane always keeps its own input value. The permuted wave is registered once. The output valid trails the input valid by one clock.

Internally a decoder classifies the code into an operation kind (pass, quad, row shift left/right, row rotate, four wave moves, two mirrors, two broadcasts). A router computes one source index and a validity bit per lane, and a lane selector applies the masks and the fallback rule. There is no multi-cycle sequencing: every operation takes one transfer.

Top module: `xlp_top`

## Requirements
- R1: For codes 0x00–0xFF, lane i of every aligned four-lane group takes the group lane given by code bits [2(i mod 4)+1 : 2(i mod 4)].
- R2: For codes 0x101–0x10F (N = code[3:0]), in-row position p takes position p+N of the same row; if p+N > 15 the source is invalid.
- R3: For codes 0x111–0x11F, in-row position p takes position p−N; if p < N the source is invalid.
- R4: For codes 0x121–0x12F, in-row position p takes position (p−N) mod 16; no lane is invalid.
- R5: Whole-wave moves over lanes 0–63. Code 0x130: lane l takes l+1, and lane 63 is invalid. Code 0x134: lane l takes (l+1) mod 64. Code 0x138: lane l takes l−1, and lane 0 is invalid. Code 0x13C: lane l takes (l−1) mod 64.
- R6: Code 0x140 gives in-row position p the value of position 15−p; code 0x141 gives it position 8·(p div 8)+7−(p mod 8).
- R7: Code 0x142 fills every lane of row r ≥ 1 with lane 16r−1, and row 0 is invalid. Code 0x143 fills every lane of rows 2 and 3 with lane 31, and rows 0–1 are invalid.
- R8: An enabled lane with an invalid source outputs its own input value when bound_zero is 0 and zero when bound_zero is 1.
- R9: A lane in row r and bank b (b = position div 4) is enabled only when row_mask[r] and bank_mask[b] are both 1. A disabled lane outputs its own input value whatever the code and bound_zero.
- R10: Every code not listed in R1–R7 (including 0x100, 0x110, 0x120, 0x131, 0x144–0x1FF) outputs every lane unchanged.
- R11: lanes_out is loaded on the clock edge where in_valid is 1 and holds otherwise. out_valid equals in_valid of the previous cycle. Reset clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| lanes_in | input | 64*DW | Lane l at bits [l*DW +: DW] |
| perm_code | input | 9 | Permutation control code |
| bound_zero | input | 1 | Fallback select for invalid sources: 0 own value, 1 zero |
| bank_mask | input | 4 | Bit b enables bank b in each enabled row |
| row_mask | input | 4 | Bit r enables row r |
| out_valid | output | 1 | lanes_out holds a fresh result |
| lanes_out | output | 64*DW | Permuted wave, same lane layout |

## Verification
The bench sweeps all 512 control codes and checks every lane against a behavioural model. The sweep catches an off-by-one in the shift amount, a rotate that fails to wrap at position 0, and a unassigned code decoded as a neighbouring op, since each of these corrupts specific lanes. The edges of the wave and of each row are checked with bound_zero at both values. A design that mixed up the fallback would show the own value where zero belongs, or the reverse, on lane 63, lane 0 or row 0. Partial row and bank masks are combined with broadcasts and shifts, so a bank index taken from the wrong bits, or a mask applied after the fallback, shows up on individual banks. A hold cycle with changed inputs and in_valid low catches an output register that loads without a valid.

// File: rtl/xlp_pkg.sv
package xlp_pkg;
    localparam int CODE_W = 9;

    typedef enum logic [3:0] {
        OP_PASS,
        OP_QUAD,
        OP_ROW_SHL,
        OP_ROW_SHR,
        OP_ROW_ROR,
        OP_WAVE_SHL,
        OP_WAVE_ROL,
        OP_WAVE_SHR,
        OP_WAVE_ROR,
        OP_MIRROR,
        OP_HALF_MIRROR,
        OP_BCAST_ROW,
        OP_BCAST_31
    } xlp_op_e;

    typedef struct packed {
        xlp_op_e    op;
        logic [3:0] amt;
        logic [7:0] quad;
    } xlp_ctl_t;
endpackage

// File: rtl/xlp_decode.sv
module xlp_decode
    import xlp_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output xlp_ctl_t          ctl
);
    always_comb begin
        ctl.op   = OP_PASS;
        ctl.amt  = code[3:0];
        ctl.quad = code[7:0];
        if (!code[8]) begin
            ctl.op = OP_QUAD;
        end else begin
            unique case (code[7:4])
                4'h0: if (code[3:0] != 4'd0) ctl.op = OP_ROW_SHL;
                4'h1: if (code[3:0] != 4'd0) ctl.op = OP_ROW_SHR;
                4'h2: if (code[3:0] != 4'd0) ctl.op = OP_ROW_ROR;
                4'h3: begin
                    unique case (code[3:0])
                        4'h0:    ctl.op = OP_WAVE_SHL;
                        4'h4:    ctl.op = OP_WAVE_ROL;
                        4'h8:    ctl.op = OP_WAVE_SHR;
                        4'hC:    ctl.op = OP_WAVE_ROR;
                        default: ctl.op = OP_PASS;
                    endcase
                end
                4'h4: begin
                    unique case (code[3:0])
                        4'h0:    ctl.op = OP_MIRROR;
                        4'h1:    ctl.op = OP_HALF_MIRROR;
                        4'h2:    ctl.op = OP_BCAST_ROW;
                        4'h3:    ctl.op = OP_BCAST_31;
                        default: ctl.op = OP_PASS;
                    endcase
                end
                default: ctl.op = OP_PASS;
            endcase
        end
    end
endmodule

// File: rtl/xlp_route.sv
module xlp_route
    import xlp_pkg::*;
#(
    parameter int ROWS       = 4,
    parameter int BANKS      = 4,
    parameter int BANK_LANES = 4,
    localparam int ROW_LANES = BANKS * BANK_LANES,
    localparam int LANES     = ROWS * ROW_LANES,
    localparam int IDX_W     = $clog2(LANES)
)(
    input  xlp_ctl_t                    ctl,
    output logic [LANES-1:0][IDX_W-1:0] src_idx,
    output logic [LANES-1:0]            src_ok
);
    localparam int HALF = ROW_LANES / 2;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int ROW  = l / ROW_LANES;
        localparam int POS  = l % ROW_LANES;
        localparam int QPOS = l % BANK_LANES;
        localparam int BASE = ROW * ROW_LANES;

        always_comb begin
            int  s;
            int  n;
            logic ok;
            n  = int'(ctl.amt);
            s  = l;
            ok = 1'b1;
            unique case (ctl.op)
                OP_QUAD:        s = (l - QPOS) + int'(ctl.quad[2*QPOS +: 2]);
                OP_ROW_SHL: begin
                    ok = (POS + n) < ROW_LANES;
                    s  = ok ? BASE + POS + n : l;
                end
                OP_ROW_SHR: begin
                    ok = POS >= n;
                    s  = ok ? l - n : l;
                end
                OP_ROW_ROR:     s = BASE + ((POS - n + ROW_LANES) % ROW_LANES);
                OP_WAVE_SHL: begin
                    ok = l < LANES - 1;
                    s  = ok ? l + 1 : l;
                end
                OP_WAVE_ROL:    s = (l + 1) % LANES;
                OP_WAVE_SHR: begin
                    ok = l > 0;
                    s  = ok ? l - 1 : l;
                end
                OP_WAVE_ROR:    s = (l + LANES - 1) % LANES;
                OP_MIRROR:      s = BASE + (ROW_LANES - 1 - POS);
                OP_HALF_MIRROR: s = BASE + (POS / HALF) * HALF + (HALF - 1 - (POS % HALF));
                OP_BCAST_ROW: begin
                    ok = ROW >= 1;
                    s  = ok ? BASE - 1 : l;
                end
                OP_BCAST_31: begin
                    ok = ROW >= 2;
                    s  = ok ? 2 * ROW_LANES - 1 : l;
                end
                default:        s = l;
            endcase
            // R2: a valid source never leaves the wave
            p_src_in_range_r2: assert (!ok || (s >= 0 && s < LANES));
            src_idx[l] = IDX_W'(s);
            src_ok[l]  = ok;
        end
    end
endmodule

// File: rtl/xlp_lane_mux.sv
module xlp_lane_mux #(
    parameter int DW         = 32,
    parameter int ROWS       = 4,
    parameter int BANKS      = 4,
    parameter int BANK_LANES = 4,
    localparam int ROW_LANES = BANKS * BANK_LANES,
    localparam int LANES     = ROWS * ROW_LANES,
    localparam int IDX_W     = $clog2(LANES)
)(
    input  logic [LANES*DW-1:0]         lanes_in,
    input  logic [LANES-1:0][IDX_W-1:0] src_idx,
    input  logic [LANES-1:0]            src_ok,
    input  logic                        bound_zero,
    input  logic [BANKS-1:0]            bank_mask,
    input  logic [ROWS-1:0]             row_mask,
    output logic [LANES*DW-1:0]         lanes_next
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int ROW  = l / ROW_LANES;
        localparam int BANK = (l % ROW_LANES) / BANK_LANES;

        logic [DW-1:0] own;
        logic [DW-1:0] pick;
        logic          en;

        assign own  = lanes_in[l*DW +: DW];
        assign pick = lanes_in[int'(src_idx[l])*DW +: DW];
        assign en   = row_mask[ROW] & bank_mask[BANK];

        always_comb begin
            if (!en)              lanes_next[l*DW +: DW] = own;
            else if (src_ok[l])   lanes_next[l*DW +: DW] = pick;
            else if (bound_zero)  lanes_next[l*DW +: DW] = '0;
            else                  lanes_next[l*DW +: DW] = own;
        end
    end
endmodule

// File: rtl/xlp_top.sv
module xlp_top
    import xlp_pkg::*;
#(
    parameter int DW         = 32,
    parameter int ROWS       = 4,
    parameter int BANKS      = 4,
    parameter int BANK_LANES = 4,
    localparam int ROW_LANES = BANKS * BANK_LANES,
    localparam int LANES     = ROWS * ROW_LANES,
    localparam int IDX_W     = $clog2(LANES)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [LANES*DW-1:0] lanes_in,
    input  logic [CODE_W-1:0]   perm_code,
    input  logic                bound_zero,
    input  logic [BANKS-1:0]    bank_mask,
    input  logic [ROWS-1:0]     row_mask,
    output logic                out_valid,
    output logic [LANES*DW-1:0] lanes_out
);
    xlp_ctl_t                    ctl;
    logic [LANES-1:0][IDX_W-1:0] src_idx;
    logic [LANES-1:0]            src_ok;
    logic [LANES*DW-1:0]         lanes_next;

    xlp_decode u_decode (
        .code (perm_code),
        .ctl  (ctl)
    );

    xlp_route #(
        .ROWS(ROWS), .BANKS(BANKS), .BANK_LANES(BANK_LANES)
    ) u_route (
        .ctl     (ctl),
        .src_idx (src_idx),
        .src_ok  (src_ok)
    );

    xlp_lane_mux #(
        .DW(DW), .ROWS(ROWS), .BANKS(BANKS), .BANK_LANES(BANK_LANES)
    ) u_mux (
        .lanes_in   (lanes_in),
        .src_idx    (src_idx),
        .src_ok     (src_ok),
        .bound_zero (bound_zero),
        .bank_mask  (bank_mask),
        .row_mask   (row_mask),
        .lanes_next (lanes_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            lanes_out <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) lanes_out <= lanes_next;
        end
    end

    // R11: valid trails by one clock, output holds without valid
    p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(lanes_out));

    // R9: lane 0 in a disabled row keeps its own value
    p_row_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !row_mask[0]) |=> lanes_out[DW-1:0] == $past(lanes_in[DW-1:0]));

    // R8 / R7: row 0 under a row broadcast with zero fill
    p_bcast_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && perm_code == 9'h142 && bound_zero && row_mask[0] && bank_mask[0])
        |=> lanes_out[DW-1:0] == '0);

    // R10: highest unassigned code passes the whole wave
    p_unassigned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && perm_code == 9'h1FF) |=> lanes_out == $past(lanes_in));
endmodule

// File: tb/xlp_top_tb.sv
module xlp_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 32;
    localparam int NL  = 64;
    localparam int LW  = NL * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [LW-1:0] lanes_in = '0;
    logic [8:0]    perm_code = '0;
    logic          bound_zero = 1'b0;
    logic [3:0]    bank_mask = 4'hF;
    logic [3:0]    row_mask = 4'hF;
    logic          out_valid;
    logic [LW-1:0] lanes_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlp_top #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lanes_in(lanes_in),
        .perm_code(perm_code), .bound_zero(bound_zero), .bank_mask(bank_mask),
        .row_mask(row_mask), .out_valid(out_valid), .lanes_out(lanes_out)
    );

    function automatic logic [LW-1:0] pattern(int salt);
        logic [LW-1:0] d;
        for (int l = 0; l < NL; l++)
            d[l*DW +: DW] = DW'(l * 32'h9E3779B1) ^ DW'(salt * 32'h01000193) ^ 32'h00010000;
        return d;
    endfunction

    function automatic logic [LW-1:0] model(int code, bit bnd, bit [3:0] bm, bit [3:0] rm,
                                            logic [LW-1:0] d);
        logic [LW-1:0] q;
        for (int l = 0; l < NL; l++) begin
            int r = l / 16;
            int p = l % 16;
            int src = l;
            logic [DW-1:0] own = d[l*DW +: DW];
            if (code < 256) src = (l & ~3) + ((code >> (2 * (l % 4))) & 3);
            else if (code >= 257 && code <= 271) src = (p + code - 256 < 16) ? l + code - 256 : -1;
            else if (code >= 273 && code <= 287) src = (p >= code - 272) ? l - (code - 272) : -1;
            else if (code >= 289 && code <= 303) src = r * 16 + (p - (code - 288) + 16) % 16;
            else if (code == 304) src = (l < 63) ? l + 1 : -1;
            else if (code == 308) src = (l + 1) % 64;
            else if (code == 312) src = (l > 0) ? l - 1 : -1;
            else if (code == 316) src = (l + 63) % 64;
            else if (code == 320) src = r * 16 + 15 - p;
            else if (code == 321) src = r * 16 + (p / 8) * 8 + 7 - (p % 8);
            else if (code == 322) src = (r > 0) ? r * 16 - 1 : -1;
            else if (code == 323) src = (r >= 2) ? 31 : -1;
            if (!(rm[r] && bm[p / 4])) q[l*DW +: DW] = own;
            else if (src >= 0)         q[l*DW +: DW] = d[src*DW +: DW];
            else                       q[l*DW +: DW] = bnd ? '0 : own;
        end
        return q;
    endfunction

    function automatic string tag_of(int code);
        if (code < 256) return "R1";
        if (code >= 257 && code <= 271) return "R2";
        if (code >= 273 && code <= 287) return "R3";
        if (code >= 289 && code <= 303) return "R4";
        if (code == 304 || code == 308 || code == 312 || code == 316) return "R5";
        if (code == 320 || code == 321) return "R6";
        if (code == 322 || code == 323) return "R7";
        return "R10";
    endfunction

    task automatic check_lanes(string tag, logic [LW-1:0] exp);
        n_tests++;
        if (lanes_out !== exp) begin
            n_fail++;
            for (int l = 0; l < NL; l++)
                if (lanes_out[l*DW +: DW] !== exp[l*DW +: DW]) begin
                    $display("FAIL %s code=%h lane %0d: actual %h expected %h",
                             tag, perm_code, l, lanes_out[l*DW +: DW], exp[l*DW +: DW]);
                    break;
                end
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s out_valid: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic run(string tag, int code, bit bnd, bit [3:0] bm, bit [3:0] rm, int salt);
        logic [LW-1:0] d = pattern(salt);
        logic [LW-1:0] exp = model(code, bnd, bm, rm, d);
        lanes_in = d; perm_code = 9'(code); bound_zero = bnd;
        bank_mask = bm; row_mask = rm; in_valid = 1'b1;
        @(negedge clk);
        check_lanes(tag, exp);
        check_bit("R11", out_valid, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [LW-1:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        check_lanes("R11", '0);
        check_bit("R11", out_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep every code with all lanes enabled, both fallback settings
        for (int c = 0; c < 512; c++) begin
            run(tag_of(c), c, 1'b0, 4'hF, 4'hF, c);
            if (c >= 256) run(tag_of(c), c, 1'b1, 4'hF, 4'hF, c + 7);
        end

        // R8: edges with zero fill and own-value fill
        run("R8", 304, 1'b1, 4'hF, 4'hF, 900);
        run("R8", 312, 1'b0, 4'hF, 4'hF, 901);
        run("R8", 271, 1'b1, 4'hF, 4'hF, 902);
        run("R8", 273, 1'b1, 4'hF, 4'hF, 903);
        run("R8", 323, 1'b1, 4'hF, 4'hF, 904);

        // R9: partial masks against several operations
        run("R9", 322, 1'b1, 4'b1010, 4'b1101, 910);
        run("R9", 323, 1'b1, 4'b0110, 4'b0111, 911);
        run("R9", 264, 1'b1, 4'b1001, 4'b1011, 912);
        run("R9", 8'h1B, 1'b0, 4'b0011, 4'b1110, 913);
        run("R9", 316, 1'b1, 4'b0000, 4'hF, 914);
        run("R9", 308, 1'b1, 4'hF, 4'b0000, 915);
        run("R9", 320, 1'b0, 4'b0100, 4'b0010, 916);

        // R11: without valid the output holds and valid drops
        held = model(320, 1'b0, 4'b0100, 4'b0010, pattern(916));
        in_valid = 1'b0; lanes_in = pattern(999); perm_code = 9'h130;
        @(negedge clk);
        check_lanes("R11", held);
        check_bit("R11", out_valid, 1'b0);
        run("R11", 321, 1'b0, 4'hF, 4'hF, 920);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule